// File: doc/BRIEF.md
# Multi-Mode Windowed Watchdog Supervisor

This block supervises a host microcontroller. Software proves it is alive by writing a trigger word, made of a command code, a period index and a prescale setting. The block checks each trigger against a timer whose period comes from a ten-entry parameter table multiplied by a power-of-two prescale factor. The checking rule depends on the chip operating state supplied on `op_mode`. In start-up and normal states the block runs a window check: a trigger that comes too early or too late requests a system reset. In standby, sleep and flash states it runs a time-out check: any trigger before expiry is accepted, and an expiry either wakes the host or resets it.

In standby and sleep a stop command can be given. It does not stop the timer at once. The stop only takes effect at the end of a period, and only after the supply-current monitor has reported a low current since the command. The block has two outputs, both single-cycle pulses: a reset request and a cyclic wake-up. After a reset request the timer goes back to its longest period.

Top module: `wdt_supervisor`

## Requirements
- R1: After `rst_n` is released, both outputs are low and the timer runs with period index 9 and scale code 3, starting from zero in the cycle after reset.
- R2: The period P is BASE_TBL[idx] multiplied by 2 to the power of scale. The index is 4 bits wide and the scale is 2 bits wide, so the factors are 1, 2, 4 and 8. Edge k counts clock edges after the edge that restarted the timer.
- R3: Window mode applies when `op_mode` is anything other than 2, 3 or 4. A restart command (code 3'b101) sampled at edge k with P/2 < k <= P is accepted. It restarts the timer and loads the new index and scale.
- R4: In window mode, a trigger at edge k <= P/2 gives a `wdt_rst_req` pulse in the cycle after that edge.
- R5: In window mode, if no trigger arrives by edge P, a reset request follows edge P. A trigger at edge P itself is still accepted.
- R6: Time-out mode applies in states 2 (standby), 3 (sleep) and 4 (flash), and any legal trigger at k <= P is accepted. An expiry at edge P gives a one-cycle `wdt_wake` pulse and a new period in states 2 and 3. In state 4 it gives a reset request.
- R7: A restart command loads the new index and scale in every state except sleep (3). In sleep it restarts the timer and keeps the current period.
- R8: Any of the following gives a reset request in the cycle after the write: a code other than 3'b101 or 3'b110, a restart command with an index of 10 or more, or the stop code 3'b110 outside states 2 and 3.
- R9: A stop command (3'b110) in state 2 or 3 restarts the timer and arms the stop. At a later expiry, the timer halts with no wake pulse if `low_cur` has been high at any edge since the arming edge, the expiry edge included. Otherwise the timer keeps producing wake pulses. While halted, the block raises neither output.
- R10: A legal trigger, or `op_mode` leaving states 2 and 3, cancels a pending stop and restarts a halted timer from zero.
- R11: Each reset event gives exactly one high cycle of `wdt_rst_req`. The timer then restarts from zero with index 9, scale 3 and no stop pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_mode | input | 3 | Chip operating state: 0 start-up, 1 normal, 2 standby, 3 sleep, 4 flash |
| trig_we | input | 1 | Trigger write strobe, one cycle per write |
| trig_code | input | 3 | Command code: 3'b101 restart, 3'b110 stop |
| trig_idx | input | 4 | Period table index carried by the write |
| trig_scale | input | 2 | Prescale code carried by the write |
| low_cur | input | 1 | Host supply current is below the monitoring threshold |
| wdt_rst_req | output | 1 | One-cycle system reset request |
| wdt_wake | output | 1 | One-cycle cyclic wake-up pulse |

## Verification
Both outputs are registered. A reset request or wake pulse caused by the write or expiry sampled at one rising edge is high exactly during the following cycle, and nothing appears before that edge. A behavioural model in the bench keeps the elapsed edge count, the period and the stop state as plain integers. It applies the same one-edge rule and predicts both outputs for every cycle. Outputs are compared on each falling edge, half a cycle after they change. Stimulus is placed a fixed number of edges after each restart, so the window bounds k = P/2 and k = P+1 are each hit on both sides.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic [2:0] {
      OPM_START   = 3'd0,
      OPM_NORMAL  = 3'd1,
      OPM_STANDBY = 3'd2,
      OPM_SLEEP   = 3'd3,
      OPM_FLASH   = 3'd4
   } opm_e;

   localparam logic [2:0] CODE_RESTART = 3'b101;
   localparam logic [2:0] CODE_STOP    = 3'b110;

   typedef struct packed {
      logic restart;
      logic stop;
      logic bad;
   } wdt_cmd_t;

   typedef enum logic [2:0] {
      EV_IDLE,
      EV_TICK,
      EV_RESTART,
      EV_RESET,
      EV_WAKE,
      EV_HALT
   } wdt_ev_e;

   function automatic logic is_lowpwr(input logic [2:0] m);
      return (m == OPM_STANDBY) || (m == OPM_SLEEP);
   endfunction

   function automatic logic is_timeout(input logic [2:0] m);
      return (m == OPM_STANDBY) || (m == OPM_SLEEP) || (m == OPM_FLASH);
   endfunction

endpackage

// File: rtl/wdt_period_lut.sv
module wdt_period_lut #(
   parameter int          CW       = 24,
   parameter int          NUM_PER  = 10,
   parameter int          IDXW     = 4,
   parameter int          SCW      = 2,
   parameter int unsigned BASE_TBL [NUM_PER] = '{16, 24, 32, 48, 64, 96, 128, 192, 256, 384}
) (
   input  logic [IDXW-1:0] idx,
   input  logic [SCW-1:0]  scale,
   output logic [CW-1:0]   period,
   output logic [CW-1:0]   half
);
   localparam int NSCALE   = 1 << SCW;
   localparam int MAXSHIFT = NSCALE - 1;

   if (NUM_PER > (1 << IDXW)) begin : g_bad_idxw
      $error("period table larger than index range");
   end

   logic [CW-1:0] base_w [NUM_PER];
   logic [CW-1:0] base_sel;
   logic [CW-1:0] scaled [NSCALE];

   for (genvar g = 0; g < NUM_PER; g++) begin : g_tbl
      if (BASE_TBL[g] < 2) begin : g_bad_min
         $error("period table entry below 2 cycles");
      end
      if ((longint'(BASE_TBL[g]) << MAXSHIFT) >= (longint'(1) << CW)) begin : g_bad_w
         $error("scaled period exceeds counter width");
      end
      assign base_w[g] = CW'(BASE_TBL[g]);
   end

   always_comb begin
      base_sel = base_w[0];
      for (int i = 1; i < NUM_PER; i++) begin
         if (idx == IDXW'(i)) base_sel = base_w[i];
      end
   end

   for (genvar s = 0; s < NSCALE; s++) begin : g_scale
      assign scaled[s] = base_sel << s;
   end

   assign period = scaled[scale];
   assign half   = period >> 1;

endmodule

// File: rtl/wdt_cmd_check.sv
module wdt_cmd_check
   import wdt_pkg::*;
#(
   parameter int IDXW    = 4,
   parameter int NUM_PER = 10
) (
   input  logic            we,
   input  logic [2:0]      code,
   input  logic [IDXW-1:0] idx,
   input  logic [2:0]      op_mode,
   output wdt_cmd_t        cmd
);
   logic is_rst_code;
   logic is_stop_code;
   logic idx_ok;
   logic stop_ok;

   assign is_rst_code  = (code == CODE_RESTART);
   assign is_stop_code = (code == CODE_STOP);
   assign idx_ok       = ({1'b0, idx} < (IDXW+1)'(NUM_PER));
   assign stop_ok      = is_lowpwr(op_mode);

   always_comb begin
      cmd = '0;
      if (we) begin
         if (is_rst_code && idx_ok)        cmd.restart = 1'b1;
         else if (is_stop_code && stop_ok) cmd.stop    = 1'b1;
         else                              cmd.bad     = 1'b1;
      end
   end

endmodule

// File: rtl/wdt_timer_core.sv
module wdt_timer_core
   import wdt_pkg::*;
#(
   parameter int CW        = 24,
   parameter int IDXW      = 4,
   parameter int SCW       = 2,
   parameter int DEF_IDX   = 9,
   parameter int DEF_SCALE = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      op_mode,
   input  wdt_cmd_t        cmd,
   input  logic [IDXW-1:0] trig_idx,
   input  logic [SCW-1:0]  trig_scale,
   input  logic            low_cur,
   input  logic [CW-1:0]   period,
   input  logic [CW-1:0]   half,
   output logic [IDXW-1:0] cur_idx,
   output logic [SCW-1:0]  cur_scale,
   output logic            rst_req,
   output logic            wake
);
   localparam logic [IDXW-1:0] IDX0 = IDXW'(DEF_IDX);
   localparam logic [SCW-1:0]  SC0  = SCW'(DEF_SCALE);

   logic [CW-1:0] cnt;
   logic          off_arm;
   logic          low_seen;
   logic          halted;
   logic          win;
   logic          lp;
   logic          at_end;
   logic          early;
   wdt_ev_e       ev;

   assign win    = !is_timeout(op_mode);
   assign lp     = is_lowpwr(op_mode);
   assign at_end = !halted && (cnt == period - CW'(1));
   assign early  = !halted && win && (cnt < half);

   always_comb begin
      if (cmd.bad)                        ev = EV_RESET;
      else if (cmd.restart || cmd.stop)   ev = early ? EV_RESET : EV_RESTART;
      else if (at_end) begin
         if (win)                         ev = EV_RESET;
         else if (lp)                     ev = (off_arm && (low_seen || low_cur)) ? EV_HALT : EV_WAKE;
         else                             ev = EV_RESET;
      end
      else if (halted)                    ev = EV_IDLE;
      else                                ev = EV_TICK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         cur_idx   <= IDX0;
         cur_scale <= SC0;
         off_arm   <= 1'b0;
         low_seen  <= 1'b0;
         halted    <= 1'b0;
         rst_req   <= 1'b0;
         wake      <= 1'b0;
      end else begin
         rst_req <= 1'b0;
         wake    <= 1'b0;
         unique case (ev)
            EV_RESET: begin
               cnt       <= '0;
               cur_idx   <= IDX0;
               cur_scale <= SC0;
               off_arm   <= 1'b0;
               low_seen  <= 1'b0;
               halted    <= 1'b0;
               rst_req   <= 1'b1;
            end
            EV_RESTART: begin
               cnt      <= '0;
               halted   <= 1'b0;
               off_arm  <= cmd.stop;
               low_seen <= 1'b0;
               if (cmd.restart && (op_mode != OPM_SLEEP)) begin
                  cur_idx   <= trig_idx;
                  cur_scale <= trig_scale;
               end
            end
            EV_WAKE: begin
               cnt  <= '0;
               wake <= 1'b1;
               if (off_arm && low_cur) low_seen <= 1'b1;
            end
            EV_HALT: begin
               cnt      <= '0;
               halted   <= 1'b1;
               off_arm  <= 1'b0;
               low_seen <= 1'b0;
            end
            EV_TICK: begin
               cnt <= cnt + CW'(1);
               if (off_arm && low_cur) low_seen <= 1'b1;
            end
            default: begin
               if (off_arm && low_cur) low_seen <= 1'b1;
            end
         endcase
         if (!lp && (ev != EV_RESET)) begin
            off_arm  <= 1'b0;
            low_seen <= 1'b0;
            halted   <= 1'b0;
         end
      end
   end

   AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < period); // R2
   AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd.restart, cmd.stop, cmd.bad})); // R8
   AST_RST_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (cnt == '0 && cur_idx == IDX0 && cur_scale == SC0 && !halted && !off_arm)); // R11
   AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rst_req, wake})); // R6
   AST_WAKE_LOWPWR: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> $past(is_lowpwr(op_mode))); // R6
   AST_HALT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> $past(low_cur || low_seen)); // R9
   AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (cnt == '0 && !wake)); // R9
   AST_HALT_LOWPWR: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> $past(is_lowpwr(op_mode))); // R10

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
   import wdt_pkg::*;
#(
   parameter int          CW        = 24,
   parameter int          NUM_PER   = 10,
   parameter int          IDXW      = 4,
   parameter int          SCW       = 2,
   parameter int          DEF_IDX   = NUM_PER - 1,
   parameter int          DEF_SCALE = (1 << SCW) - 1,
   parameter int unsigned BASE_TBL [NUM_PER] = '{16, 24, 32, 48, 64, 96, 128, 192, 256, 384}
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      op_mode,
   input  logic            trig_we,
   input  logic [2:0]      trig_code,
   input  logic [IDXW-1:0] trig_idx,
   input  logic [SCW-1:0]  trig_scale,
   input  logic            low_cur,
   output logic            wdt_rst_req,
   output logic            wdt_wake
);
   if (DEF_IDX >= NUM_PER) begin : g_bad_def
      $error("default index outside period table");
   end

   wdt_cmd_t         cmd;
   logic [IDXW-1:0]  cur_idx;
   logic [SCW-1:0]   cur_scale;
   logic [CW-1:0]    period;
   logic [CW-1:0]    half;

   wdt_cmd_check #(.IDXW(IDXW), .NUM_PER(NUM_PER)) u_cmd (
      .we      (trig_we),
      .code    (trig_code),
      .idx     (trig_idx),
      .op_mode (op_mode),
      .cmd     (cmd)
   );

   wdt_period_lut #(.CW(CW), .NUM_PER(NUM_PER), .IDXW(IDXW), .SCW(SCW),
                    .BASE_TBL(BASE_TBL)) u_lut (
      .idx    (cur_idx),
      .scale  (cur_scale),
      .period (period),
      .half   (half)
   );

   wdt_timer_core #(.CW(CW), .IDXW(IDXW), .SCW(SCW), .DEF_IDX(DEF_IDX),
                    .DEF_SCALE(DEF_SCALE)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_mode    (op_mode),
      .cmd        (cmd),
      .trig_idx   (trig_idx),
      .trig_scale (trig_scale),
      .low_cur    (low_cur),
      .period     (period),
      .half       (half),
      .cur_idx    (cur_idx),
      .cur_scale  (cur_scale),
      .rst_req    (wdt_rst_req),
      .wake       (wdt_wake)
   );

endmodule

// File: tb/sim_wdt_supervisor.sv
module sim_wdt_supervisor;
   localparam int          NP = 10;
   localparam int unsigned TBL [NP] = '{4, 6, 8, 10, 12, 14, 16, 18, 20, 22};
   localparam logic [2:0]  KICK = 3'b101;
   localparam logic [2:0]  STOP = 3'b110;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] op_mode = 3'd1;
   logic       trig_we = 1'b0;
   logic [2:0] trig_code = 3'd0;
   logic [3:0] trig_idx = 4'd0;
   logic [1:0] trig_scale = 2'd0;
   logic       low_cur = 1'b0;
   logic       wdt_rst_req;
   logic       wdt_wake;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #5 clk = ~clk;

   wdt_supervisor #(.CW(16), .NUM_PER(NP), .BASE_TBL(TBL)) u0 (
      .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .trig_we(trig_we),
      .trig_code(trig_code), .trig_idx(trig_idx), .trig_scale(trig_scale),
      .low_cur(low_cur), .wdt_rst_req(wdt_rst_req), .wdt_wake(wdt_wake)
   );

   // behavioural reference: elapsed edges since restart, period in cycles
   int    m_age, m_idx, m_sc;
   bit    m_run, m_arm, m_seen, m_rst, m_wake;
   string m_why = "R1";

   function automatic int per_of(int i, int s);
      return int'(TBL[i]) * (1 << s);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_age = 0; m_idx = 9; m_sc = 3; m_run = 1; m_arm = 0; m_seen = 0;
         m_rst = 0; m_wake = 0; m_why = "R1";
      end else begin
         bit lp, tmo, win, do_rst, reload, halt;
         int p;
         lp  = (op_mode == 3'd2) || (op_mode == 3'd3);
         tmo = lp || (op_mode == 3'd4);
         win = !tmo;
         p   = per_of(m_idx, m_sc);
         do_rst = 0; reload = 0; halt = 0;
         m_rst = 0; m_wake = 0;
         if (trig_we) begin
            if (!((trig_code == KICK && trig_idx < 4'd10) || (trig_code == STOP && lp))) begin
               do_rst = 1; m_why = "R8";
            end else if (m_run && win && (m_age + 1) <= p / 2) begin
               do_rst = 1; m_why = "R4";
            end else begin
               reload = 1; m_age = 0; m_run = 1; m_seen = 0;
               m_arm = (trig_code == STOP);
               if (trig_code == KICK && op_mode != 3'd3) begin
                  m_idx = int'(trig_idx); m_sc = int'(trig_scale);
               end
               m_why = (trig_code == STOP) ? "R9" : "R7";
            end
         end else if (m_run && (m_age + 1) == p) begin
            if (win) begin
               do_rst = 1; m_why = "R5";
            end else if (lp && m_arm && (m_seen || low_cur)) begin
               halt = 1; m_run = 0; m_age = 0; m_arm = 0; m_seen = 0; m_why = "R9";
            end else if (lp) begin
               m_wake = 1; m_age = 0; m_why = "R6";
            end else begin
               do_rst = 1; m_why = "R6";
            end
         end else if (m_run) begin
            m_age++;
         end
         if (do_rst) begin
            m_rst = 1; m_age = 0; m_idx = 9; m_sc = 3; m_run = 1; m_arm = 0; m_seen = 0;
         end else begin
            if (!reload && !halt && m_arm && low_cur) m_seen = 1;
            if (!lp) begin
               m_arm = 0; m_seen = 0;
               if (!m_run) begin m_run = 1; m_age = 0; m_why = "R10"; end
            end
         end
      end
   end

   // compare every cycle, half a cycle after the outputs move
   always @(negedge clk) begin
      cyc++;
      n_cmp++;
      if (wdt_rst_req !== m_rst || wdt_wake !== m_wake) begin
         n_bad++;
         $display("FAIL %s cyc=%0d rst_req=%b/%b wake=%b/%b (actual/expected)",
                  m_why, cyc, wdt_rst_req, m_rst, wdt_wake, m_wake);
      end
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic trig(logic [2:0] c, logic [3:0] i, logic [1:0] s);
      @(negedge clk); #1;
      trig_we = 1; trig_code = c; trig_idx = i; trig_scale = s;
      @(negedge clk); #1;
      trig_we = 0; trig_code = 3'd0;
   endtask

   // trigger sampled at edge k after the most recent restart edge (k >= 2)
   task automatic trig_at(int k, logic [2:0] c, logic [3:0] i, logic [1:0] s);
      if (k > 2) idle(k - 2);
      trig(c, i, s);
   endtask

   task automatic mode(logic [2:0] m);
      @(negedge clk); #1; op_mode = m;
   endtask

   task automatic wait_rst();
      int guard = 0;
      do begin @(negedge clk); guard++; end while (!wdt_rst_req && guard < 400);
      #1;
   endtask

   initial begin
      idle(3);
      // R1: outputs idle during and straight after reset
      n_cmp++;
      if (wdt_rst_req !== 1'b0 || wdt_wake !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 reset outputs %b%b expected 00", wdt_rst_req, wdt_wake);
      end
      rst_n = 1;
      // R1/R5: default period 22*8 with no trigger ends in a late reset
      wait_rst();
      // R3/R2: mid-window restart, new period 4
      trig_at(100, KICK, 4'd0, 2'd0);
      trig_at(4, KICK, 4'd0, 2'd0);   // R5 latest valid edge
      trig_at(3, KICK, 4'd0, 2'd0);   // R3 earliest valid edge
      trig_at(2, KICK, 4'd0, 2'd0);   // R4 too early
      wait_rst();
      // R2: index 2, scale 1 gives 16 cycles; then late expiry R5
      trig_at(100, KICK, 4'd2, 2'd1);
      trig_at(9, KICK, 4'd2, 2'd1);
      trig_at(8, KICK, 4'd2, 2'd1);   // R4 boundary at P/2
      wait_rst();
      trig_at(100, KICK, 4'd2, 2'd1);
      idle(20);                        // R5 late
      wait_rst();
      // R8: illegal code, bad index, stop in normal state
      trig_at(100, 3'b011, 4'd0, 2'd0);
      wait_rst();
      trig_at(100, KICK, 4'd12, 2'd0);
      wait_rst();
      trig_at(100, STOP, 4'd0, 2'd0);
      wait_rst();
      // R6: standby time-out with wake pulses, early trigger accepted
      mode(3'd2);
      trig_at(100, KICK, 4'd1, 2'd1);
      idle(40);
      trig_at(2, KICK, 4'd1, 2'd1);
      // R7: sleep restart keeps the 12-cycle period
      mode(3'd3);
      trig_at(5, KICK, 4'd0, 2'd0);
      idle(30);
      // R6: flash expiry is a reset
      mode(3'd4);
      trig_at(3, KICK, 4'd0, 2'd1);
      idle(12);
      wait_rst();
      // R9: stop armed, no low current, wakes continue; then halts
      mode(3'd2);
      trig_at(3, KICK, 4'd0, 2'd1);
      trig_at(3, STOP, 4'd0, 2'd0);
      idle(30);
      @(negedge clk); #1; low_cur = 1;
      @(negedge clk); #1; low_cur = 0;
      idle(40);
      // R10: leaving low power restarts the halted timer
      mode(3'd1);
      idle(20);
      wait_rst();
      // R10: restart command revives a halted timer in sleep
      mode(3'd2);
      trig_at(100, KICK, 4'd0, 2'd0);
      trig_at(2, STOP, 4'd0, 2'd0);
      low_cur = 1;
      idle(12);
      low_cur = 0;
      mode(3'd3);
      idle(5);
      trig(KICK, 4'd0, 2'd0);
      idle(12);
      // R11 and mixed traffic from a pseudo-random sequence
      begin
         logic [15:0] lf = 16'hACE1;
         for (int n = 0; n < 4000; n++) begin
            @(negedge clk); #1;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            trig_we   = (lf[4:0] == 5'd3);
            trig_code = lf[6] ? KICK : (lf[7] ? STOP : lf[10:8]);
            trig_idx  = {1'b0, lf[11:9]};
            trig_scale = lf[13:12];
            low_cur   = lf[14] & lf[2];
            if (lf[9:0] == 10'd17) op_mode = 3'(lf[15:13] % 5);
         end
         trig_we = 0; low_cur = 0;
      end
      idle(5);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule